// File: doc/BRIEF.md
# Programmable Bank Chip-Select Decoder

This block turns the top three bits of an 18-bit address into four active-low memory selects. Each select covers one or more 32 kB segments. A default ROM select covers the lower 64 kB. A fixed select covers 0x10000–0x2FFFF and does not depend on any register. Two card-slot selects cover the segments enabled in two 8-bit mask registers.

Software sets up the map by writing the two masks over the shared 8-bit data bus, using a register chip-enable and a write strobe. It can read the masks back on the same bus. A card select takes precedence over the default ROM in any segment it claims. An I/O-exclusion chip-enable turns all four selects off so that an I/O window can sit inside a mapped segment. A low register chip-enable does the same. All selects are combinational from the address, the enables and the current register contents.

Top module: `bank_cs_decoder`

## Requirements
- R1: After rst_ni goes low, both mask registers hold 0x00.
- R2: While reg_ce_ni is low, a rising edge of wr_ni loads data_io into a register. addr_a0_i = 0 selects the mask for card0_cs_no and addr_a0_i = 1 selects the mask for card1_cs_no.
- R3: Bit n of a mask register asserts the matching card select low when seg_i (address bits 17..15) equals n, provided no exclusion is active.
- R4: fix_cs_no is low exactly when seg_i is 2, 3, 4 or 5, regardless of mask contents, provided no exclusion is active.
- R5: rom_cs_no is low when seg_i is 0 or 1 and neither card select claims that segment.
- R6: While io_ce_ni is low or reg_ce_ni is low, all four selects are high.
- R7: When rd_ni and reg_ce_ni are both low, data_io carries the register chosen by addr_a0_i. At all other times the block leaves data_io undriven.
- R8: When both masks enable the same segment, both card selects assert and rom_cs_no stays high.
- R9: Mask bits 2 and 3 are decoded like any other bit, even though they cover segments that collide with on-board RAM.
- R10: A wr_ni rising edge while reg_ce_ni is high changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_i | input | 3 | Address bits 17..15 |
| addr_a0_i | input | 1 | Address bit 0, selects the register |
| reg_ce_ni | input | 1 | Register chip-enable, active low |
| io_ce_ni | input | 1 | I/O-window exclusion enable, active low |
| wr_ni | input | 1 | Write strobe, active low; the register loads on its rising edge |
| rd_ni | input | 1 | Read strobe, active low |
| data_io | inout | 8 | Shared data bus |
| rom_cs_no | output | 1 | Default ROM select, active low |
| fix_cs_no | output | 1 | Fixed-range select, active low |
| card0_cs_no | output | 1 | First card select, active low |
| card1_cs_no | output | 1 | Second card select, active low |

## Verification
The hardest state to reach from the ports is overlap. It needs both masks to claim the same default-ROM segment, and then needs the exclusion enables to override that claim. The bench programs each register pair through the real strobe sequence, then sweeps the segment inputs, with some vectors holding io_ce_ni low. Writes that set bits 2 or 3 are flagged while the bench still checks that those bits are decoded. Bus release is observed through pull-ups on data_io, so an undriven bus reads 0xFF.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned ADDR_W   = 18;
  localparam int unsigned SEG_W    = 3;
  localparam int unsigned N_SEG    = 1 << SEG_W;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_REG    = 2;
  localparam int unsigned REG_SEL_W = $clog2(N_REG);
  typedef logic [N_SEG-1:0] seg_mask_t;
  typedef struct packed {
    logic rom_n;
    logic fix_n;
    logic card0_n;
    logic card1_n;
  } cs_vec_t;
endpackage

// File: rtl/bcs_cfg_regs.sv
module bcs_cfg_regs
  import bcs_pkg::*;
(
  input  logic                     rst_ni,
  input  logic                     wr_ni,
  input  logic                     rd_ni,
  input  logic                     ce_ni,
  input  logic [REG_SEL_W-1:0]     sel_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     drive_o,
  output seg_mask_t [N_REG-1:0]    mask_o
);
  seg_mask_t [N_REG-1:0] regs_q;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    always_ff @(posedge wr_ni or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (!ce_ni && sel_i == REG_SEL_W'(g))    regs_q[g] <= wdata_i;
    end
  end

  assign mask_o  = regs_q;
  assign rdata_o = regs_q[sel_i];
  assign drive_o = !rd_ni && !ce_ni;

  always_comb begin
    if (rd_ni) AST_IDLE_BUS: assert (!drive_o); // R7
  end
endmodule

// File: rtl/bcs_seg_decode.sv
module bcs_seg_decode
  import bcs_pkg::*;
#(
  parameter seg_mask_t DEF_MASK = 8'h03,
  parameter seg_mask_t FIX_MASK = 8'h3C
) (
  input  logic [SEG_W-1:0]         seg_i,
  input  seg_mask_t [N_REG-1:0]    mask_i,
  output logic [N_REG-1:0]         card_hit_o,
  output logic                     def_hit_o,
  output logic                     fix_hit_o
);
  seg_mask_t seg_oh;

  for (genvar s = 0; s < N_SEG; s++) begin : g_oh
    assign seg_oh[s] = (seg_i == SEG_W'(s));
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_card
    assign card_hit_o[r] = |(mask_i[r] & seg_oh);
  end

  // cards win over the default ROM
  assign def_hit_o = |(DEF_MASK & seg_oh) && !(|card_hit_o);
  assign fix_hit_o = |(FIX_MASK & seg_oh);

  always_comb begin
    AST_ONE_SEG: assert ($onehot(seg_oh));
    if (|card_hit_o) AST_CARD_WINS: assert (!def_hit_o); // R8
  end
endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
  import bcs_pkg::*;
#(
  parameter seg_mask_t DEF_MASK = 8'h03,
  parameter seg_mask_t FIX_MASK = 8'h3C
) (
  input  logic              rst_ni,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic              addr_a0_i,
  input  logic              reg_ce_ni,
  input  logic              io_ce_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  inout  wire  [DATA_W-1:0] data_io,
  output logic              rom_cs_no,
  output logic              fix_cs_no,
  output logic              card0_cs_no,
  output logic              card1_cs_no
);
  seg_mask_t [N_REG-1:0] mask;
  logic [DATA_W-1:0]     rdata;
  logic                  drive;
  logic [N_REG-1:0]      card_hit;
  logic                  def_hit, fix_hit, veto;
  cs_vec_t               cs;

  bcs_cfg_regs i_regs (
    .rst_ni  (rst_ni),
    .wr_ni   (wr_ni),
    .rd_ni   (rd_ni),
    .ce_ni   (reg_ce_ni),
    .sel_i   (addr_a0_i),
    .wdata_i (data_io),
    .rdata_o (rdata),
    .drive_o (drive),
    .mask_o  (mask)
  );

  bcs_seg_decode #(.DEF_MASK(DEF_MASK), .FIX_MASK(FIX_MASK)) i_dec (
    .seg_i      (seg_i),
    .mask_i     (mask),
    .card_hit_o (card_hit),
    .def_hit_o  (def_hit),
    .fix_hit_o  (fix_hit)
  );

  assign data_io = drive ? rdata : 'z;

  assign veto = !reg_ce_ni || !io_ce_ni;
  always_comb begin
    cs.rom_n   = veto || !def_hit;
    cs.fix_n   = veto || !fix_hit;
    cs.card0_n = veto || !card_hit[0];
    cs.card1_n = veto || !card_hit[1];
  end

  assign rom_cs_no   = cs.rom_n;
  assign fix_cs_no   = cs.fix_n;
  assign card0_cs_no = cs.card0_n;
  assign card1_cs_no = cs.card1_n;

  always_comb begin
    if (veto) AST_HOLE_VETO: assert (&{rom_cs_no, fix_cs_no, card0_cs_no, card1_cs_no}); // R6
    if (!card0_cs_no || !card1_cs_no) AST_ROM_YIELDS: assert (rom_cs_no); // R5
    AST_ROM_FIX_DISJOINT: assert (rom_cs_no || fix_cs_no); // R4
  end
endmodule

// File: tb/test_bank_cs_decoder.sv
module test_bank_cs_decoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] seg = '0;
  logic       a0 = 1'b0, reg_ce_n = 1'b1, io_ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_data = '0;
  wire  [7:0] data_io;
  logic rom_n, fix_n, c0_n, c1_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign data_io = tb_drv ? tb_data : 'z;
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (data_io[i]);
  end

  bank_cs_decoder i_bank_cs_decoder (
    .rst_ni(rst_ni), .seg_i(seg), .addr_a0_i(a0), .reg_ce_ni(reg_ce_n),
    .io_ce_ni(io_ce_n), .wr_ni(wr_n), .rd_ni(rd_n), .data_io(data_io),
    .rom_cs_no(rom_n), .fix_cs_no(fix_n), .card0_cs_no(c0_n), .card1_cs_no(c1_n)
  );

  // {mask0, mask1, seg, io_ce_n, expected {rom,fix,card0,card1}}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'h00, 3'd0, 1'b1, 4'b0111},  // R5
    {8'h00, 8'h00, 3'd3, 1'b1, 4'b1011},  // R4
    {8'h03, 8'h00, 3'd0, 1'b1, 4'b1101},  // R3
    {8'h03, 8'h00, 3'd1, 1'b1, 4'b1101},  // R3
    {8'h10, 8'h00, 3'd4, 1'b1, 4'b1001},  // R4
    {8'h43, 8'h00, 3'd6, 1'b1, 4'b1101},  // R3
    {8'h43, 8'h00, 3'd7, 1'b1, 4'b1111},  // R3
    {8'h00, 8'h80, 3'd7, 1'b1, 4'b1110},  // R3
    {8'h01, 8'h01, 3'd0, 1'b1, 4'b1100},  // R8
    {8'h04, 8'h00, 3'd2, 1'b1, 4'b1001},  // R9
    {8'h00, 8'h02, 3'd1, 1'b1, 4'b1110},  // R5
    {8'h03, 8'h00, 3'd0, 1'b0, 4'b1111}   // R6
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] val, input logic ce_n);
    @(negedge clk);
    if (!ce_n && (val[2] || val[3])) $display("NOTE: mask %0d=%h enables RAM-conflict segment", sel, val);
    a0 = sel; reg_ce_n = ce_n; tb_data = val; tb_drv = 1'b1;
    #0.5 wr_n = 1'b0;
    #1   wr_n = 1'b1;
    #0.5 reg_ce_n = 1'b1; tb_drv = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] val);
    @(negedge clk);
    a0 = sel; reg_ce_n = 1'b0; rd_n = 1'b0;
    #1 val = data_io;
    rd_n = 1'b1; reg_ce_n = 1'b1;
  endtask

  function automatic logic [7:0] outs();
    return {4'h0, rom_n, fix_n, c0_n, c1_n};
  endfunction

  initial begin
    logic [7:0] v;
    #7 rst_ni = 1'b1;
    rd_reg(1'b0, v); check("R1 mask0 reset", v, 8'h00);
    rd_reg(1'b1, v); check("R1 mask1 reset", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr_reg(1'b0, VEC[i][23:16], 1'b0);
      wr_reg(1'b1, VEC[i][15:8], 1'b0);
      @(negedge clk);
      seg = VEC[i][7:5]; io_ce_n = VEC[i][4];
      #1 check($sformatf("R3/R4/R5/R6/R8/R9 vec %0d", i), outs(), {4'h0, VEC[i][3:0]});
      io_ce_n = 1'b1;
    end

    wr_reg(1'b0, 8'hA5, 1'b0);
    wr_reg(1'b1, 8'h5A, 1'b0);
    rd_reg(1'b0, v); check("R2 readback mask0", v, 8'hA5);
    rd_reg(1'b1, v); check("R2 readback mask1", v, 8'h5A);

    wr_reg(1'b0, 8'hFF, 1'b1);
    rd_reg(1'b0, v); check("R10 write ignored without ce", v, 8'hA5);

    @(negedge clk); a0 = 1'b0; rd_n = 1'b0; reg_ce_n = 1'b1;
    #1 check("R7 bus released, ce high", data_io, 8'hFF);
    rd_n = 1'b1;
    @(negedge clk); reg_ce_n = 1'b0; seg = 3'd2;
    #1 check("R7 bus released, rd high", data_io, 8'hFF);
    check("R6 reg ce vetoes selects", outs(), 8'h0F);
    reg_ce_n = 1'b1;

    @(negedge clk); seg = 3'd5;
    #1 check("R4 fixed select seg5", {7'h0, fix_n}, 8'h00);

    @(negedge clk); rst_ni = 1'b0;
    #1 rst_ni = 1'b1;
    rd_reg(1'b1, v); check("R1 mask1 after reset", v, 8'h00);
    @(negedge clk); seg = 3'd0;
    #1 check("R1 default map after reset", outs(), 8'h07);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule